// File: doc/BRIEF.md
# Processor Status Flag Update Unit

This block holds the status flags of an 8-bit accumulator-style processor: negative (N), overflow (V), decimal (D), interrupt-disable (I), zero (Z) and carry (C). The decoded control word of each microinstruction drives it. That word can do one of four things:

- pass an ALU result and the ALU's carry and overflow outputs, with a mask that picks which of N, Z, C and V are written;
- run a bit-test compare;
- set or clear one flag chosen by the opcode;
- enter an interrupt, or reload the whole register from the data bus.

The block also drives the ALU's decimal-arithmetic enable. That enable is armed by a dedicated end-of-instruction strobe and only when D is set. An instruction-set selector tells the interrupt entry whether a CMOS-style set is active, because only those sets clear D on entry. The ALU itself lives elsewhere.

Top module: `psr_flag_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `status` reads 0x24 (I set, all other flags clear) and `dec_en` is 0.
- R2: `status` packs N at bit 7, V at bit 6, D at bit 3, I at bit 2, Z at bit 1 and C at bit 0. Bit 5 always reads 1 and bit 4 always reads 0.
- R3: With `upd_mask` = 4'b1100 (mask bit 3 selects N, bit 2 Z, bit 1 C, bit 0 V) and `bit_mode` low, the next `status` has N = `alu_res[7]` and Z = (`alu_res` == 0). All other flags hold.
- R4: With the C and V mask bits set and `bit_mode` low, C takes `alu_co` and V takes `alu_vo` at the next edge.
- R5: Each mask bit gates only its own flag. With `upd_mask` = 0 and no command active, `status` does not change.
- R6: When `op_flag_en` is high, `op_flag_set` is written into one flag chosen by `opcode[7:6]`: 00 selects C, 01 selects I, 10 selects V, 11 selects D. All other flags hold.
- R7: With `bit_mode` high, a selected N takes `alu_opnd[7]`, a selected V takes `alu_opnd[6]`, and a selected Z is set when `alu_res` is zero. C holds.
- R8: `irq_entry` sets I. It clears D only when `iset_sel` is 1 or 3 (CMOS-style sets); for selectors 0 and 2, D holds.
- R9: `bus_load` writes N, V, D, I, Z and C from `bus_data` bits 7, 6, 3, 2, 1 and 0 in one cycle.
- R10: `dec_en` is high for exactly the cycle after an `end_dec` strobe, and only if D was set when the strobe was sampled. Otherwise it is low.
- R11: When several commands are active together, only the highest one applies. The order is `bus_load`, then `irq_entry`, then `op_flag_en`, then the masked ALU update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_res | input | 8 | ALU result byte |
| alu_opnd | input | 8 | ALU second operand (source of N and V in bit-test mode) |
| alu_co | input | 1 | ALU carry out |
| alu_vo | input | 1 | ALU signed overflow out |
| upd_mask | input | 4 | Flag write mask: bit 3 N, bit 2 Z, bit 1 C, bit 0 V |
| bit_mode | input | 1 | Bit-test flag rule strobe |
| op_flag_en | input | 1 | Opcode-directed single flag write |
| op_flag_set | input | 1 | Value for the opcode-directed write (1 set, 0 clear) |
| opcode | input | 8 | Current opcode; bits 7:6 choose the flag |
| irq_entry | input | 1 | Interrupt-entry flag command |
| iset_sel | input | 2 | Instruction-set selector |
| bus_load | input | 1 | Load all flags from the data bus |
| bus_data | input | 8 | Data bus byte for `bus_load` |
| end_dec | input | 1 | End-of-instruction strobe that arms decimal mode |
| status | output | 8 | Flag register as packed in R2 |
| dec_en | output | 1 | Decimal-arithmetic enable for the ALU |

## Verification
Every flag lives in one register that drives `status` directly. A wrong next-state choice therefore shows on the port in the cycle right after the edge that stored it, and it stays there until a later command overwrites that flag. A bad decimal arm or a missed disarm shows on `dec_en` one cycle after `end_dec`. A bad priority or flag-select decode shows up as a neighbouring flag changing when it should have held, so each stimulus checks the whole byte and not just the target bit.

// File: rtl/psr_pkg.sv
package psr_pkg;
   // status byte layout
   localparam int unsigned ST_C = 0;
   localparam int unsigned ST_Z = 1;
   localparam int unsigned ST_I = 2;
   localparam int unsigned ST_D = 3;
   localparam int unsigned ST_B = 4;
   localparam int unsigned ST_U = 5;
   localparam int unsigned ST_V = 6;
   localparam int unsigned ST_N = 7;
   // update mask layout
   localparam int unsigned MK_V = 0;
   localparam int unsigned MK_C = 1;
   localparam int unsigned MK_Z = 2;
   localparam int unsigned MK_N = 3;
   localparam int unsigned MASK_W = 4;
   // opcode-directed flag codes
   typedef enum logic [1:0] {
      SEL_C = 2'b00,
      SEL_I = 2'b01,
      SEL_V = 2'b10,
      SEL_D = 2'b11
   } flag_sel_e;

   typedef struct packed {
      logic n;
      logic v;
      logic d;
      logic i;
      logic z;
      logic c;
   } flags_t;

   localparam flags_t FLAGS_RST = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};
endpackage

// File: rtl/psr_alu_flags.sv
module psr_alu_flags
   import psr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic [DATA_W-1:0] opnd,
   input  logic              co,
   input  logic              vo,
   input  logic              bit_mode,
   input  logic [MASK_W-1:0] mask,
   input  flags_t            cur,
   output flags_t            nxt
);
   localparam int unsigned MSB = DATA_W - 1;
   localparam int unsigned NMSB = DATA_W - 2;

   logic res_zero;
   logic n_src;
   logic v_src;
   logic [NMSB-1:0] unused_opnd;

   assign res_zero = (res == '0);
   assign n_src = bit_mode ? opnd[MSB] : res[MSB];
   assign v_src = bit_mode ? opnd[NMSB] : vo;
   assign unused_opnd = opnd[NMSB-1:0];

   always_comb begin
      nxt = cur;
      if (mask[MK_N]) nxt.n = n_src;
      if (mask[MK_Z]) nxt.z = res_zero;
      if (mask[MK_V]) nxt.v = v_src;
      if (mask[MK_C] && !bit_mode) nxt.c = co;
   end
endmodule

// File: rtl/psr_opcode_sel.sv
module psr_opcode_sel
   import psr_pkg::*;
#(
   parameter int unsigned SEL_W = 2
) (
   input  logic [SEL_W-1:0]      code,
   output logic [(1<<SEL_W)-1:0] onehot
);
   localparam int unsigned N_SEL = 1 << SEL_W;

   for (genvar k = 0; k < N_SEL; k++) begin : g_dec
      assign onehot[k] = (code == k[SEL_W-1:0]);
   end
endmodule

// File: rtl/psr_dec_gate.sv
module psr_dec_gate #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic d_flag,
   output logic dec_en
);
   if (REGISTERED) begin : g_reg
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= arm & d_flag;
      end
      assign dec_en = en_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign dec_en = arm & d_flag;
   end
endmodule

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
   import psr_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ISET_W    = 2,
   parameter logic [(1<<ISET_W)-1:0] CMOS_SETS = 4'b1010,
   parameter bit          DEC_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] alu_res,
   input  logic [DATA_W-1:0] alu_opnd,
   input  logic              alu_co,
   input  logic              alu_vo,
   input  logic [3:0]        upd_mask,
   input  logic              bit_mode,
   input  logic              op_flag_en,
   input  logic              op_flag_set,
   input  logic [7:0]        opcode,
   input  logic              irq_entry,
   input  logic [ISET_W-1:0] iset_sel,
   input  logic              bus_load,
   input  logic [7:0]        bus_data,
   input  logic              end_dec,
   output logic [7:0]        status,
   output logic              dec_en
);
   localparam int unsigned SEL_W = 2;
   localparam int unsigned N_SEL = 1 << SEL_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("psr_flag_unit: DATA_W must be at least 2");
   end
   if (MASK_W != 4) begin : g_bad_mask
      $error("psr_flag_unit: mask layout expects four flags");
   end

   flags_t flg_q;
   flags_t flg_d;
   flags_t alu_nxt;
   logic [N_SEL-1:0] sel_oh;
   logic cmos_set;
   logic [7:0] unused_bits;

   assign unused_bits = {opcode[5:0], bus_data[ST_U], bus_data[ST_B]};
   assign cmos_set = CMOS_SETS[iset_sel];

   psr_alu_flags #(.DATA_W(DATA_W)) u_alu_flags (
      .res      (alu_res),
      .opnd     (alu_opnd),
      .co       (alu_co),
      .vo       (alu_vo),
      .bit_mode (bit_mode),
      .mask     (upd_mask),
      .cur      (flg_q),
      .nxt      (alu_nxt)
   );

   psr_opcode_sel #(.SEL_W(SEL_W)) u_op_sel (
      .code   (opcode[7:6]),
      .onehot (sel_oh)
   );

   always_comb begin
      flg_d = flg_q;
      if (bus_load) begin
         flg_d.n = bus_data[ST_N];
         flg_d.v = bus_data[ST_V];
         flg_d.d = bus_data[ST_D];
         flg_d.i = bus_data[ST_I];
         flg_d.z = bus_data[ST_Z];
         flg_d.c = bus_data[ST_C];
      end else if (irq_entry) begin
         flg_d.i = 1'b1;
         if (cmos_set) flg_d.d = 1'b0;
      end else if (op_flag_en) begin
         if (sel_oh[SEL_C]) flg_d.c = op_flag_set;
         if (sel_oh[SEL_I]) flg_d.i = op_flag_set;
         if (sel_oh[SEL_V]) flg_d.v = op_flag_set;
         if (sel_oh[SEL_D]) flg_d.d = op_flag_set;
      end else begin
         flg_d = alu_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= FLAGS_RST;
      else        flg_q <= flg_d;
   end

   psr_dec_gate #(.REGISTERED(DEC_REG)) u_dec_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (end_dec),
      .d_flag (flg_q.d),
      .dec_en (dec_en)
   );

   assign status = {flg_q.n, flg_q.v, 1'b1, 1'b0, flg_q.d, flg_q.i, flg_q.z, flg_q.c};
endmodule

// File: rtl/psr_flag_unit_chk.sv
module psr_flag_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] alu_res,
   input logic [7:0] alu_opnd,
   input logic       alu_co,
   input logic [3:0] upd_mask,
   input logic       bit_mode,
   input logic       op_flag_en,
   input logic       op_flag_set,
   input logic [7:0] opcode,
   input logic       irq_entry,
   input logic       bus_load,
   input logic [7:0] bus_data,
   input logic       end_dec,
   input logic [7:0] status,
   input logic       dec_en
);
   logic no_cmd;
   assign no_cmd = !bus_load && !irq_entry && !op_flag_en;

   AST_NZ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (no_cmd && !bit_mode && upd_mask == 4'b1100) |=>
      (status[7] == $past(alu_res[7]) && status[1] == ($past(alu_res) == 8'h00)
       && status[6] == $past(status[6]) && status[0] == $past(status[0]))); // R3
   AST_CARRY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (no_cmd && !bit_mode && upd_mask[1]) |=> (status[0] == $past(alu_co))); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (no_cmd && upd_mask == 4'b0000) |=> $stable(status)); // R5
   AST_OP_SET_C: assert property (@(posedge clk) disable iff (!rst_n)
      (op_flag_en && !bus_load && !irq_entry && opcode[7:6] == 2'b00) |=>
      (status[0] == $past(op_flag_set) && status[2] == $past(status[2]))); // R6
   AST_BIT_N: assert property (@(posedge clk) disable iff (!rst_n)
      (no_cmd && bit_mode && upd_mask[3]) |=>
      (status[7] == $past(alu_opnd[7]) && status[0] == $past(status[0]))); // R7
   AST_IRQ_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_entry && !bus_load) |=> status[2]); // R8
   AST_BUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_load |=> (status[7:6] == $past(bus_data[7:6]) && status[3:0] == $past(bus_data[3:0]))); // R9
   AST_DEC_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      end_dec |=> (dec_en == $past(status[3]))); // R10
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !end_dec |=> !dec_en); // R10
endmodule

bind psr_flag_unit psr_flag_unit_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alu_res     (alu_res),
   .alu_opnd    (alu_opnd),
   .alu_co      (alu_co),
   .upd_mask    (upd_mask),
   .bit_mode    (bit_mode),
   .op_flag_en  (op_flag_en),
   .op_flag_set (op_flag_set),
   .opcode      (opcode),
   .irq_entry   (irq_entry),
   .bus_load    (bus_load),
   .bus_data    (bus_data),
   .end_dec     (end_dec),
   .status      (status),
   .dec_en      (dec_en)
);

// File: tb/psr_flag_unit_test.sv
module psr_flag_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] alu_res = '0, alu_opnd = '0, bus_data = '0, opcode = '0;
   logic alu_co = 0, alu_vo = 0, bit_mode = 0, op_flag_en = 0, op_flag_set = 0;
   logic irq_entry = 0, bus_load = 0, end_dec = 0;
   logic [3:0] upd_mask = '0;
   logic [1:0] iset_sel = '0;
   logic [7:0] status;
   logic dec_en;
   int checks = 0;
   int fails = 0;
   logic [7:0] expv;

   always #(CLK_PERIOD/2) clk = ~clk;

   psr_flag_unit uut (
      .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_opnd(alu_opnd),
      .alu_co(alu_co), .alu_vo(alu_vo), .upd_mask(upd_mask), .bit_mode(bit_mode),
      .op_flag_en(op_flag_en), .op_flag_set(op_flag_set), .opcode(opcode),
      .irq_entry(irq_entry), .iset_sel(iset_sel), .bus_load(bus_load),
      .bus_data(bus_data), .end_dec(end_dec), .status(status), .dec_en(dec_en)
   );

   // {mask[4], bit_mode, res[8], opnd[8], co, vo, expected status[8]}
   localparam logic [30:0] VEC [0:7] = '{
      {4'b1100, 1'b0, 8'h80, 8'h00, 1'b0, 1'b0, 8'hA4},  // R3 negative
      {4'b1100, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 8'h26},  // R3 zero, C/V ignored
      {4'b1111, 1'b0, 8'h7F, 8'h00, 1'b1, 1'b1, 8'h65},  // R4 carry+overflow
      {4'b1111, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h26},  // R4 cleared
      {4'b0000, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h26},  // R5 no mask
      {4'b1101, 1'b1, 8'h00, 8'hC0, 1'b0, 1'b0, 8'hE6},  // R7 operand bits
      {4'b1101, 1'b1, 8'h01, 8'h00, 1'b1, 1'b1, 8'h24},  // R7 C holds
      {4'b0010, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0, 8'h25}   // R5 carry only
   };
   localparam int VREQ [0:7] = '{3, 3, 4, 4, 5, 7, 7, 5};

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      upd_mask = '0; bit_mode = 0; op_flag_en = 0; op_flag_set = 0;
      irq_entry = 0; bus_load = 0; end_dec = 0; alu_co = 0; alu_vo = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   function automatic int flag_bit(input logic [1:0] code);
      case (code)
         2'b00: return 0;
         2'b01: return 2;
         2'b10: return 6;
         default: return 3;
      endcase
   endfunction

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      fails++;
      $display("FAIL watchdog all-R actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check8("R1 reset status", status, 8'h24);
      check8("R1 reset dec_en", {7'b0, dec_en}, 8'h00);
      rst_n = 1;
      @(negedge clk);
      check8("R1 after release", status, 8'h24);

      // table walk of the ALU flag path
      for (int k = 0; k < 8; k++) begin
         upd_mask = VEC[k][30:27]; bit_mode = VEC[k][26];
         alu_res = VEC[k][25:18]; alu_opnd = VEC[k][17:10];
         alu_co = VEC[k][9]; alu_vo = VEC[k][8];
         step();
         check8($sformatf("R%0d vector %0d", VREQ[k], k), status, VEC[k][7:0]);
      end

      // R6 opcode-directed set and clear of each flag
      expv = 8'h25;
      for (int c = 0; c < 4; c++) begin
         for (int s = 1; s >= 0; s--) begin
            opcode = {c[1:0], 1'b0, 5'h18};
            op_flag_en = 1; op_flag_set = s[0];
            alu_res = 8'h80; upd_mask = 4'b1111; alu_co = 1;
            step();
            expv[flag_bit(c[1:0])] = s[0];
            check8($sformatf("R6 code %0d set=%0d", c, s), status, expv);
         end
      end

      // R10 decimal enable: D clear -> no arm
      end_dec = 1;
      step();
      check8("R10 D clear no arm", {7'b0, dec_en}, 8'h00);
      opcode = 8'hF8; op_flag_en = 1; op_flag_set = 1;
      step();
      check8("R6 set D", status, 8'h28);
      end_dec = 1;
      step();
      check8("R10 armed", {7'b0, dec_en}, 8'h01);
      step();
      check8("R10 one cycle only", {7'b0, dec_en}, 8'h00);

      // R8 interrupt entry, NMOS selector keeps D, CMOS clears it
      iset_sel = 2'd0; irq_entry = 1;
      step();
      check8("R8 nmos keeps D", status, 8'h2C);
      iset_sel = 2'd2; irq_entry = 1;
      step();
      check8("R8 sel2 keeps D", status, 8'h2C);
      iset_sel = 2'd1; irq_entry = 1;
      step();
      check8("R8 cmos clears D", status, 8'h24);

      // R9 and R2 bus loads
      bus_data = 8'h00; bus_load = 1;
      step();
      check8("R9/R2 load zeros", status, 8'h20);
      bus_data = 8'hFF; bus_load = 1;
      step();
      check8("R9/R2 load ones", status, 8'hEF);

      // R11 priority
      bus_data = 8'h00; bus_load = 1; irq_entry = 1; iset_sel = 2'd0;
      opcode = 8'h38; op_flag_en = 1; op_flag_set = 1;
      upd_mask = 4'b1111; alu_res = 8'h80; alu_co = 1;
      step();
      check8("R11 bus wins", status, 8'h20);
      irq_entry = 1; opcode = 8'h38; op_flag_en = 1; op_flag_set = 1;
      upd_mask = 4'b1111; alu_res = 8'h80; alu_co = 1;
      step();
      check8("R11 irq over opcode", status, 8'h24);
      opcode = 8'h58; op_flag_en = 1; op_flag_set = 0;
      upd_mask = 4'b1111; alu_res = 8'h80; alu_co = 1;
      step();
      check8("R11 opcode over alu", status, 8'h20);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule